// File: doc/BRIEF.md
# Monochrome Framebuffer Scanout Engine

This block turns a packed one-bit-per-pixel framebuffer into a 640x400 monochrome video stream at a 25 MHz pixel clock. It keeps a pixel counter and a line counter, drives an active-low horizontal sync and an active-high vertical sync, and reads the framebuffer through a simple synchronous-read port: the block raises a read strobe with a byte address, and the data word comes back one clock later.

Each fetched 32-bit word feeds a shift register that sends one pixel per clock, most significant bit first. The first word of a line is requested two clocks before the line's first visible pixel, so the shifter is never empty. Every later word is requested two clocks before its first pixel. Outside the visible window the video bit is held at zero.

A line is 800 clocks and a frame is 449 lines. Lines 38 to 437 are visible. Each visible line reads 20 consecutive words, which is 80 bytes, so the line start address moves up by 80 bytes from one visible line to the next. The read address returns to the framebuffer base when the frame wraps. Every timing value is a parameter, so a shortened raster can be built for test.

Top module: `mono_scanout`

## Requirements
- R1: The pixel counter runs from 0 to H_TOTAL-1 (default 800) and then returns to 0. The line counter advances when the pixel counter wraps, and it returns to 0 after line V_TOTAL-1 (default 448). Both counters are internal. Their phase is seen at the ports through the sync outputs, and after reset it can be counted from the first clock.
- R2: `hsync_o` is low exactly while the pixel count is in [HS_START, HS_END) (default [16, 48)). It is high at every other count.
- R3: `vsync_o` is high exactly on the lines in [VS_START, VS_END) (default lines 2 and 3). It is low on every other line, and it changes only where a line starts.
- R4: A visible line is any line in [VA_START, VA_START+V_ACTIVE) (default 38 to 437). A visible pixel is any pixel count in [ACT_START, ACT_START+H_ACTIVE) (default 48 to 687). `video_o` is 0 at every other position, whatever the memory returns.
- R5: Pixel k of a visible line (k = count - ACT_START) equals bit (31 - k mod 32) of word k/32 of that line. So bit 31 goes out first and one bit leaves per clock.
- R6: `fb_rd_o` is high for one clock at each pixel count ACT_START + 32j - 2 (j = 0 .. H_ACTIVE/32 - 1) of visible lines, and at no other time. The data for each read is taken from `fb_rdata_i` one clock after the strobe.
- R7: `fb_addr_o` is a byte address. The read for word j of visible line L (L counted from VA_START) uses BASE_ADDR + L*(H_ACTIVE/8) + 4j. At pixel 0 of line 0 the address equals BASE_ADDR.
- R8: While reset is asserted (synchronous, active high), `hsync_o` is 1, `vsync_o` is 0, `video_o` is 0, `fb_rd_o` is 0 and `fb_addr_o` equals BASE_ADDR. Both counters start from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_rdata_i | input | WORD_W | Framebuffer read data, valid one clock after `fb_rd_o` |
| fb_addr_o | output | ADDR_W | Framebuffer byte address of the current read |
| fb_rd_o | output | 1 | Read strobe |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| video_o | output | 1 | Serial pixel bit |

## Verification
The hardest case to reach from the ports is a word being loaded on the wrong clock, or stale data leaking into the blanked region, because a memory that always returns the right data hides both. The bench memory therefore returns the pattern word only in the clock right after a strobe and all ones in every other clock. Any early, late or extra load then shows up on `video_o`. A shortened raster lets the bench sweep every pixel of several whole frames, including the frame wrap where the address must fall back to the base.

// File: rtl/mono_scan_pkg.sv
package mono_scan_pkg;

    // half-open window test on counter values
    function automatic logic in_span(input int x, input int lo, input int hi);
        return (x >= lo) && (x < hi);
    endfunction

    // true where a word boundary of the visible window starts
    function automatic logic word_edge(input int x, input int lo, input int hi, input int w);
        return in_span(x, lo, hi) && (((x - lo) % w) == 0);
    endfunction

endpackage

// File: rtl/scan_timing.sv
module scan_timing
    import mono_scan_pkg::*;
#(
    parameter int H_TOTAL  = 800,
    parameter int HS_START = 16,
    parameter int HS_END   = 48,
    parameter int V_TOTAL  = 449,
    parameter int VS_START = 2,
    parameter int VS_END   = 4,
    parameter int HCW      = $clog2(H_TOTAL),
    parameter int VCW      = $clog2(V_TOTAL)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [HCW-1:0] nxt_h_o,
    output logic [VCW-1:0] nxt_v_o,
    output logic           hsync_o,
    output logic           vsync_o
);
    localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL - 1);
    localparam logic [VCW-1:0] V_LAST = VCW'(V_TOTAL - 1);

    typedef struct packed {
        logic [HCW-1:0] h;
        logic [VCW-1:0] v;
        logic           hs;
        logic           vs;
    } tim_t;

    tim_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.h == H_LAST) begin
            st_d.h = '0;
            st_d.v = (st_q.v == V_LAST) ? '0 : st_q.v + 1'b1;
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
        st_d.hs = !in_span(int'(st_d.h), HS_START, HS_END);
        st_d.vs = in_span(int'(st_d.v), VS_START, VS_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{h: '0, v: '0, hs: 1'b1, vs: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_h_o = st_d.h;
    assign nxt_v_o = st_d.v;
    assign hsync_o = st_q.hs;
    assign vsync_o = st_q.vs;

    // R1: frame wrap returns both counters to zero
    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q.h == H_LAST && st_q.v == V_LAST) |=> (st_q.h == '0 && st_q.v == '0));

    // R1: pixel counter steps by one inside a line
    assert_pixel_step_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q.h != H_LAST) |=> (st_q.h == $past(st_q.h) + 1'b1));

    // R2: hsync falls only at the pulse start count
    assert_hsync_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.hs) |-> (st_q.h == HCW'(HS_START)));

    // R3: vsync changes only at a line start
    assert_vsync_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.vs != $past(st_q.vs)) |-> (st_q.h == '0));
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import mono_scan_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 15,
    parameter int BASE_ADDR = 0,
    parameter int ACT_START = 48,
    parameter int ACT_END   = 688,
    parameter int VA_START  = 38,
    parameter int VA_END    = 438,
    parameter int HCW       = 10,
    parameter int VCW       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HCW-1:0]    nxt_h_i,
    input  logic [VCW-1:0]    nxt_v_i,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
    // a read leaves this many clocks ahead of the word's first pixel
    localparam int LEAD = 2;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } fet_t;

    fet_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = in_span(int'(nxt_v_i), VA_START, VA_END)
                  && word_edge(int'(nxt_h_i) + LEAD, ACT_START, ACT_END, WORD_W);
        if (nxt_h_i == '0 && nxt_v_i == '0) begin
            st_d.addr = BASE;
        end else if (st_q.rd) begin
            st_d.addr = st_q.addr + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{rd: 1'b0, addr: BASE};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o   = st_q.rd;
    assign addr_o = st_q.addr;

    // R6: strobes are single-clock pulses
    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.rd |=> !st_q.rd);

    // R7: the word after a read sits one word higher
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.rd |=> (st_q.addr == $past(st_q.addr) + STEP));
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter
    import mono_scan_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ACT_START = 48,
    parameter int ACT_END   = 688,
    parameter int VA_START  = 38,
    parameter int VA_END    = 438,
    parameter int HCW       = 10,
    parameter int VCW       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HCW-1:0]    nxt_h_i,
    input  logic [VCW-1:0]    nxt_v_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              video_o
);
    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic              act;
        logic              video;
    } shf_t;

    shf_t st_d, st_q;
    logic line_vis;
    logic load;

    always_comb begin
        st_d     = st_q;
        line_vis = in_span(int'(nxt_v_i), VA_START, VA_END);
        load     = line_vis && word_edge(int'(nxt_h_i), ACT_START, ACT_END, WORD_W);
        if (load) begin
            st_d.shift = rdata_i;
        end else begin
            st_d.shift = {st_q.shift[WORD_W-2:0], 1'b0};
        end
        st_d.act   = line_vis && in_span(int'(nxt_h_i), ACT_START, ACT_END);
        st_d.video = st_d.act && st_d.shift[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{shift: '0, act: 1'b0, video: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign video_o = st_q.video;

    // R4: no lit pixel outside the visible window
    assert_blank_outside_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.video |-> st_q.act);
endmodule

// File: rtl/mono_scanout.sv
module mono_scanout #(
    parameter int H_TOTAL   = 800,
    parameter int HS_START  = 16,
    parameter int HS_END    = 48,
    parameter int ACT_START = 48,
    parameter int H_ACTIVE  = 640,
    parameter int V_TOTAL   = 449,
    parameter int VS_START  = 2,
    parameter int VS_END    = 4,
    parameter int VA_START  = 38,
    parameter int V_ACTIVE  = 400,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 15,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fb_rdata_i,
    output logic [ADDR_W-1:0] fb_addr_o,
    output logic              fb_rd_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              video_o
);
    localparam int HCW     = $clog2(H_TOTAL);
    localparam int VCW     = $clog2(V_TOTAL);
    localparam int ACT_END = ACT_START + H_ACTIVE;
    localparam int VA_END  = VA_START + V_ACTIVE;

    logic [HCW-1:0] nxt_h;
    logic [VCW-1:0] nxt_v;

    scan_timing #(
        .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_END),
        .V_TOTAL(V_TOTAL), .VS_START(VS_START), .VS_END(VS_END),
        .HCW(HCW), .VCW(VCW)
    ) u_timing (
        .clk(clk), .rst(rst),
        .nxt_h_o(nxt_h), .nxt_v_o(nxt_v),
        .hsync_o(hsync_o), .vsync_o(vsync_o)
    );

    scan_fetch #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .ACT_START(ACT_START), .ACT_END(ACT_END),
        .VA_START(VA_START), .VA_END(VA_END),
        .HCW(HCW), .VCW(VCW)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .nxt_h_i(nxt_h), .nxt_v_i(nxt_v),
        .rd_o(fb_rd_o), .addr_o(fb_addr_o)
    );

    scan_shifter #(
        .WORD_W(WORD_W), .ACT_START(ACT_START), .ACT_END(ACT_END),
        .VA_START(VA_START), .VA_END(VA_END),
        .HCW(HCW), .VCW(VCW)
    ) u_shifter (
        .clk(clk), .rst(rst),
        .nxt_h_i(nxt_h), .nxt_v_i(nxt_v),
        .rdata_i(fb_rdata_i), .video_o(video_o)
    );

    // R4: pixels never overlap the horizontal sync pulse
    assert_video_not_in_hsync_R4: assert property (@(posedge clk) disable iff (rst)
        video_o |-> hsync_o);

    // R6: strobes only during visible pixel-side fetch windows, never in vertical sync
    assert_no_read_in_vsync_R6: assert property (@(posedge clk) disable iff (rst)
        fb_rd_o |-> !vsync_o);
endmodule

// File: tb/mono_scanout_tb.sv
module mono_scanout_tb;
    localparam int HT = 96, HSS = 4, HSE = 12, AS = 14, HA = 64;
    localparam int VT = 20, VSS = 2, VSE = 4, VAS = 6, VA = 10;
    localparam int BASE = 'h100;
    localparam int STRIDE = HA / 8;
    localparam int FRAME = HT * VT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rdata;
    logic [15:0] addr;
    logic        rd, hs, vs, vid;

    int n_cmp = 0;
    int n_bad = 0;
    int eh = 0;
    int ev = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mono_scanout #(
        .H_TOTAL(HT), .HS_START(HSS), .HS_END(HSE), .ACT_START(AS), .H_ACTIVE(HA),
        .V_TOTAL(VT), .VS_START(VSS), .VS_END(VSE), .VA_START(VAS), .V_ACTIVE(VA),
        .WORD_W(32), .ADDR_W(16), .BASE_ADDR(BASE)
    ) u_dut (
        .clk(clk), .rst(rst), .fb_rdata_i(rdata), .fb_addr_o(addr),
        .fb_rd_o(rd), .hsync_o(hs), .vsync_o(vs), .video_o(vid)
    );

    function automatic logic [31:0] pat(input int a);
        logic [31:0] x;
        x = 32'(a) * 32'h9E37_79B1;
        return x ^ 32'hC3A5_0F96;
    endfunction

    // memory: valid data only in the clock after a strobe, all ones otherwise
    always @(posedge clk) begin
        rdata <= rd ? pat(int'(addr)) : 32'hFFFF_FFFF;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at line %0d pixel %0d: actual=%0h expected=%0h", tag, ev, eh, act, exp);
        end
    endtask

    task automatic compare();
        bit line_vis, px_vis, e_hs, e_vs, e_rd, e_vid;
        int k, j, e_addr;
        e_hs = !(eh >= HSS && eh < HSE);
        e_vs = (ev >= VSS && ev < VSE);
        line_vis = (ev >= VAS && ev < VAS + VA);
        px_vis = line_vis && eh >= AS && eh < AS + HA;
        e_vid = 1'b0;
        if (px_vis) begin
            k = eh - AS;
            e_vid = pat(BASE + (ev - VAS) * STRIDE + (k / 32) * 4)[31 - (k % 32)];
        end
        e_rd = line_vis && (eh + 2 >= AS) && (eh + 2 < AS + HA) && (((eh + 2 - AS) % 32) == 0);
        chk(hs == e_hs, "R2 hsync", int'(hs), int'(e_hs));
        chk(vs == e_vs, "R3 vsync", int'(vs), int'(e_vs));
        chk(vid == e_vid, px_vis ? "R5 pixel bit" : "R4 blank", int'(vid), int'(e_vid));
        chk(rd == e_rd, "R6 read strobe", int'(rd), int'(e_rd));
        if (e_rd) begin
            j = (eh + 2 - AS) / 32;
            e_addr = BASE + (ev - VAS) * STRIDE + j * 4;
            chk(int'(addr) == e_addr, "R7 read address", int'(addr), e_addr);
        end
        if (eh == 0 && ev == 0)
            chk(int'(addr) == BASE, "R7 frame base", int'(addr), BASE);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(hs == 1'b1, "R8 reset hsync", int'(hs), 1);
        chk(vs == 1'b0, "R8 reset vsync", int'(vs), 0);
        chk(vid == 1'b0, "R8 reset video", int'(vid), 0);
        chk(rd == 1'b0, "R8 reset strobe", int'(rd), 0);
        chk(int'(addr) == BASE, "R8 reset address", int'(addr), BASE);
        rst = 1'b0;
        eh = 0;
        ev = 0;
        compare();
        // R1: counters followed arithmetically over three whole frames
        for (int c = 0; c < 3 * FRAME + 40; c++) begin
            @(negedge clk);
            if (eh == HT - 1) begin
                eh = 0;
                ev = (ev == VT - 1) ? 0 : ev + 1;
            end else begin
                eh = eh + 1;
            end
            compare();
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule